// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns the already-decoded addressing fields of a memory operand into a linear address. Each cycle it receives an addressing mode, two register numbers (base and index), a two-bit scale code, a signed 32-bit displacement, the full contents of the eight general registers, and the base values of the data and stack segments. It adds the terms that the mode calls for to the base of the chosen segment. The sum wraps modulo 2^32.

The segment is chosen from the base register. Register 5 (the frame pointer) selects the stack segment. Every other base register, and every mode that has no base register, selects the data segment. Register 4 (the stack pointer) is refused as an index, and also as a base. Any such refused encoding, and any mode code outside the six defined ones, raises an illegal flag.

Results are captured on the clock edge at which `in_valid` is high. They appear one cycle later together with `out_valid`, and they hold until the next valid input.

Top module: `seg_eagen`

Register numbering: 0, 1, 2, 3, 6 and 7 are ordinary registers, 4 is the stack pointer and 5 is the frame pointer. Register n sits in `in_gpr[32n+31:32n]`.

Mode codes: 0 direct, 1 register indirect, 2 base-plus-index, 3 register relative, 4 base relative-plus-index, 5 scaled-index. Codes 6 and 7 are undefined.

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid`, `out_addr`, `out_seg` and `out_illegal` all at 0.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge. When `in_valid` is low, `out_addr`, `out_seg` and `out_illegal` keep their values, whatever the other inputs do.
- R3: In mode 0 (direct), the address is data segment base + displacement, and `out_seg` is 0. The base and index fields are ignored, so register 4 in them raises no flag.
- R4: In mode 1 (register indirect), the address is segment base + base register. The index field and the displacement are ignored.
- R5: In mode 2 (base-plus-index), the address is segment base + base register + index register. The displacement and the scale code are ignored.
- R6: In mode 3 (register relative), the address is segment base + base register + displacement. The displacement is a signed two's-complement value.
- R7: In mode 4 (base relative-plus-index), the address is segment base + base register + index register + displacement. The scale code is ignored.
- R8: In mode 5 (scaled-index), the address is segment base + base register + (index register shifted left by the scale code 0..3, i.e. ×1, ×2, ×4, ×8) + displacement.
- R9: In modes 1 to 5, a base field of 5 selects the stack segment base and sets `out_seg` to 1. Any other base field selects the data segment base and sets `out_seg` to 0.
- R10: `out_illegal` is 1 in three cases: the mode code is 6 or 7; the mode is 1 to 5 and the base field is 4; or the mode is 2, 4 or 5 and the index field is 4. Whenever `out_illegal` is 1, `out_addr` is 0. `out_seg` still follows R9.
- R11: All additions wrap modulo 2^32 and give no carry indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture the operand fields on this edge |
| in_mode | input | 3 | Addressing mode code |
| in_base | input | 3 | Base register number |
| in_index | input | 3 | Index register number |
| in_scale | input | 2 | Index shift amount, used in scaled-index mode |
| in_disp | input | 32 | Signed displacement |
| in_gpr | input | 256 | The eight general registers, register n at bits 32n+31..32n |
| in_ds_base | input | 32 | Data segment base |
| in_ss_base | input | 32 | Stack segment base |
| out_valid | output | 1 | Registered result is fresh |
| out_addr | output | 32 | Linear address, 0 when illegal |
| out_seg | output | 1 | 1 = stack segment used, 0 = data segment |
| out_illegal | output | 1 | Encoding was refused |

## Verification
Two functions can act in the same cycle: segment selection from a frame-pointer base, and rejection of the stack pointer as index. The bench provokes this with scaled-index mode, base 5 and index 4 in one input. It expects `out_seg` at 1 together with `out_illegal` at 1 and a zero address. A second overlap is a new valid input arriving in the same cycle the previous result is shown. Back-to-back valid inputs are compared with the reference model on every edge, which shows that results are neither lost nor smeared.

// File: rtl/eag_pkg.sv
// Package eag_pkg
// Shared mode codes and the decoded term-selection record for the
// effective address generator. Assumes a 3-bit mode field.
package eag_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] AM_DIRECT       = 3'd0;
    localparam logic [MODE_W-1:0] AM_REG_IND      = 3'd1;
    localparam logic [MODE_W-1:0] AM_BASE_IDX     = 3'd2;
    localparam logic [MODE_W-1:0] AM_REG_REL      = 3'd3;
    localparam logic [MODE_W-1:0] AM_BASE_REL_IDX = 3'd4;
    localparam logic [MODE_W-1:0] AM_SCALED       = 3'd5;

    // Which address terms the current mode adds in.
    typedef struct packed {
        logic mode_ok;
        logic use_base;
        logic use_index;
        logic use_scale;
        logic use_disp;
    } term_sel_t;

endpackage

// File: rtl/eag_mode_decode.sv
// Module eag_mode_decode
// Purely combinational. Turns the mode code into a term-selection record.
// Flags refused encodings (undefined mode, stack pointer as base or as index)
// and picks the stack segment when the frame pointer is the base.
// Assumes the register numbers for stack and frame pointer are given as parameters.
module eag_mode_decode
    import eag_pkg::*;
#(
    parameter int REG_IDX_W = 3,
    parameter int SP_IDX    = 4,
    parameter int FP_IDX    = 5
) (
    input  logic [MODE_W-1:0]    mode,
    input  logic [REG_IDX_W-1:0] base_idx,
    input  logic [REG_IDX_W-1:0] index_idx,
    output term_sel_t            terms,
    output logic                 stack_seg,
    output logic                 illegal
);

    localparam logic [REG_IDX_W-1:0] SP_CODE = REG_IDX_W'(SP_IDX);
    localparam logic [REG_IDX_W-1:0] FP_CODE = REG_IDX_W'(FP_IDX);

    // Map the mode code onto the set of terms it uses.
    always_comb begin
        terms = '0;
        case (mode)
            AM_DIRECT: begin
                terms.mode_ok  = 1'b1;
                terms.use_disp = 1'b1;
            end
            AM_REG_IND: begin
                terms.mode_ok  = 1'b1;
                terms.use_base = 1'b1;
            end
            AM_BASE_IDX: begin
                terms.mode_ok   = 1'b1;
                terms.use_base  = 1'b1;
                terms.use_index = 1'b1;
            end
            AM_REG_REL: begin
                terms.mode_ok  = 1'b1;
                terms.use_base = 1'b1;
                terms.use_disp = 1'b1;
            end
            AM_BASE_REL_IDX: begin
                terms.mode_ok   = 1'b1;
                terms.use_base  = 1'b1;
                terms.use_index = 1'b1;
                terms.use_disp  = 1'b1;
            end
            AM_SCALED: begin
                terms.mode_ok   = 1'b1;
                terms.use_base  = 1'b1;
                terms.use_index = 1'b1;
                terms.use_scale = 1'b1;
                terms.use_disp  = 1'b1;
            end
            default: terms = '0;
        endcase
    end

    // Segment choice and refusal checks on the register fields.
    always_comb begin
        stack_seg = terms.use_base && (base_idx == FP_CODE);
        illegal   = !terms.mode_ok
                  || (terms.use_base  && (base_idx  == SP_CODE))
                  || (terms.use_index && (index_idx == SP_CODE));
    end

endmodule

// File: rtl/eag_operand_sel.sv
// Module eag_operand_sel
// Combinational. Reads the base and index registers out of the flattened
// register file and applies the index shift. Terms the mode does not use
// are forced to zero. Assumes NREG is a power of two covered by REG_IDX_W.
module eag_operand_sel #(
    parameter int DATA_W    = 32,
    parameter int NREG      = 8,
    parameter int REG_IDX_W = 3,
    parameter int SCALE_W   = 2
) (
    input  logic [NREG*DATA_W-1:0] gpr_flat,
    input  logic [REG_IDX_W-1:0]   base_idx,
    input  logic [REG_IDX_W-1:0]   index_idx,
    input  logic [SCALE_W-1:0]     scale_code,
    input  logic                   use_base,
    input  logic                   use_index,
    input  logic                   use_scale,
    output logic [DATA_W-1:0]      base_term,
    output logic [DATA_W-1:0]      index_term
);

    localparam int NSCALE = 1 << SCALE_W;

    logic [DATA_W-1:0] regs   [NREG];
    logic [DATA_W-1:0] scaled [NSCALE];
    logic [DATA_W-1:0] base_val;
    logic [DATA_W-1:0] index_val;
    logic [SCALE_W-1:0] shift_sel;

    // Split the flat register bus into one word per register.
    for (genvar r = 0; r < NREG; r++) begin : g_unpack
        assign regs[r] = gpr_flat[r*DATA_W +: DATA_W];
    end

    // Build one shifted copy of the index for each scale code.
    for (genvar s = 0; s < NSCALE; s++) begin : g_scale
        assign scaled[s] = index_val << s;
    end

    // Register reads.
    always_comb begin
        base_val  = regs[base_idx];
        index_val = regs[index_idx];
        shift_sel = use_scale ? scale_code : '0;
    end

    // Gate the terms by the mode.
    always_comb begin
        base_term  = use_base  ? base_val          : '0;
        index_term = use_index ? scaled[shift_sel] : '0;
    end

endmodule

// File: rtl/eag_adder.sv
// Module eag_adder
// Combinational four-operand sum. Wraps modulo 2^DATA_W and drops the carry.
// Assumes unused terms arrive already zeroed.
module eag_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] seg_term,
    input  logic [DATA_W-1:0] base_term,
    input  logic [DATA_W-1:0] index_term,
    input  logic [DATA_W-1:0] disp_term,
    output logic [DATA_W-1:0] sum
);

    logic [DATA_W-1:0] pair_a;
    logic [DATA_W-1:0] pair_b;

    // Balanced tree of two-input adds.
    always_comb begin
        pair_a = seg_term + disp_term;
        pair_b = base_term + index_term;
        sum    = pair_a + pair_b;
    end

endmodule

// File: rtl/seg_eagen.sv
// Module seg_eagen (top)
// Forms a linear address from decoded operand fields and registers it with
// one cycle of latency. Outputs hold while in_valid is low. A refused
// encoding gives a zero address with the illegal flag set.
// Assumes synchronous active-low reset and one register file snapshot per input.
module seg_eagen
    import eag_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NREG    = 8,
    parameter int SCALE_W = 2,
    parameter int SP_IDX  = 4,
    parameter int FP_IDX  = 5,
    localparam int REG_IDX_W = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [MODE_W-1:0]      in_mode,
    input  logic [REG_IDX_W-1:0]   in_base,
    input  logic [REG_IDX_W-1:0]   in_index,
    input  logic [SCALE_W-1:0]     in_scale,
    input  logic [DATA_W-1:0]      in_disp,
    input  logic [NREG*DATA_W-1:0] in_gpr,
    input  logic [DATA_W-1:0]      in_ds_base,
    input  logic [DATA_W-1:0]      in_ss_base,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_addr,
    output logic                   out_seg,
    output logic                   out_illegal
);

    term_sel_t         terms;
    logic              stack_seg;
    logic              illegal;
    logic [DATA_W-1:0] base_term;
    logic [DATA_W-1:0] index_term;
    logic [DATA_W-1:0] seg_term;
    logic [DATA_W-1:0] disp_term;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] next_addr;

    eag_mode_decode #(
        .REG_IDX_W (REG_IDX_W),
        .SP_IDX    (SP_IDX),
        .FP_IDX    (FP_IDX)
    ) u_decode (
        .mode      (in_mode),
        .base_idx  (in_base),
        .index_idx (in_index),
        .terms     (terms),
        .stack_seg (stack_seg),
        .illegal   (illegal)
    );

    eag_operand_sel #(
        .DATA_W    (DATA_W),
        .NREG      (NREG),
        .REG_IDX_W (REG_IDX_W),
        .SCALE_W   (SCALE_W)
    ) u_opsel (
        .gpr_flat   (in_gpr),
        .base_idx   (in_base),
        .index_idx  (in_index),
        .scale_code (in_scale),
        .use_base   (terms.use_base),
        .use_index  (terms.use_index),
        .use_scale  (terms.use_scale),
        .base_term  (base_term),
        .index_term (index_term)
    );

    // Segment base and displacement selection.
    always_comb begin
        seg_term  = stack_seg ? in_ss_base : in_ds_base;
        disp_term = terms.use_disp ? in_disp : '0;
    end

    eag_adder #(
        .DATA_W (DATA_W)
    ) u_add (
        .seg_term   (seg_term),
        .base_term  (base_term),
        .index_term (index_term),
        .disp_term  (disp_term),
        .sum        (sum)
    );

    // A refused encoding yields a zero address.
    always_comb begin
        next_addr = illegal ? '0 : sum;
    end

    // Valid flag follows the input valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the result on valid inputs and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr    <= '0;
            out_seg     <= 1'b0;
            out_illegal <= 1'b0;
        end else if (in_valid) begin
            out_addr    <= next_addr;
            out_seg     <= stack_seg;
            out_illegal <= illegal;
        end
    end

endmodule

// File: rtl/eag_checker.sv
// Module eag_checker
// Temporal properties for seg_eagen, attached by bind. Sees the ports only.
module eag_checker #(
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 3,
    parameter int SP_IDX    = 4,
    parameter int FP_IDX    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [2:0]           in_mode,
    input logic [REG_IDX_W-1:0] in_base,
    input logic [REG_IDX_W-1:0] in_index,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    out_addr,
    input logic                 out_seg,
    input logic                 out_illegal
);

    logic base_mode;
    logic index_mode;

    // Classify the incoming mode code.
    always_comb begin
        base_mode  = (in_mode >= 3'd1) && (in_mode <= 3'd5);
        index_mode = (in_mode == 3'd2) || (in_mode == 3'd4) || (in_mode == 3'd5);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_illegal && !out_seg && out_addr == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_addr) && $stable(out_seg) && $stable(out_illegal)));

    a_r3_direct_data_seg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 3'd0) |=> (!out_seg && !out_illegal));

    a_r9_frame_stack_seg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && base_mode && in_base == REG_IDX_W'(FP_IDX)) |=> out_seg);

    a_r10_sp_index_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && index_mode && in_index == REG_IDX_W'(SP_IDX)) |=> out_illegal);

    a_r10_undefined_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode >= 3'd6) |=> out_illegal);

    a_r10_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_addr == '0);

endmodule

bind seg_eagen eag_checker #(
    .DATA_W    (DATA_W),
    .REG_IDX_W (REG_IDX_W),
    .SP_IDX    (SP_IDX),
    .FP_IDX    (FP_IDX)
) u_eag_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_mode     (in_mode),
    .in_base     (in_base),
    .in_index    (in_index),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_seg     (out_seg),
    .out_illegal (out_illegal)
);

// File: tb/tb_seg_eagen.sv
// Bench for seg_eagen: behavioural reference model updated on each rising
// edge, compared with the outputs on every falling edge.
module tb_seg_eagen;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_mode = '0;
    logic [2:0]   in_base = '0;
    logic [2:0]   in_index = '0;
    logic [1:0]   in_scale = '0;
    logic [31:0]  in_disp = '0;
    logic [255:0] in_gpr = '0;
    logic [31:0]  in_ds_base = '0;
    logic [31:0]  in_ss_base = '0;
    logic         out_valid;
    logic [31:0]  out_addr;
    logic         out_seg;
    logic         out_illegal;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] regs [8];
    string cur_tag = "R1";

    logic        exp_valid = 1'b0;
    logic [31:0] exp_addr = '0;
    logic        exp_seg = 1'b0;
    logic        exp_ill = 1'b0;
    string       exp_tag = "R1";
    bit          model_live = 1'b0;

    always #2 clk = ~clk;

    seg_eagen dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_mode (in_mode),
        .in_base (in_base), .in_index (in_index), .in_scale (in_scale),
        .in_disp (in_disp), .in_gpr (in_gpr), .in_ds_base (in_ds_base),
        .in_ss_base (in_ss_base), .out_valid (out_valid), .out_addr (out_addr),
        .out_seg (out_seg), .out_illegal (out_illegal)
    );

    // Requirement-level reference: address, segment and refusal flag.
    function automatic void ref_calc(output logic [31:0] a, output logic sg,
                                     output logic il);
        logic [31:0] b = regs[in_base];
        logic [31:0] x = regs[in_index];
        logic [31:0] sb;
        bit has_base = (in_mode >= 1) && (in_mode <= 5);
        bit has_idx  = (in_mode == 2) || (in_mode == 4) || (in_mode == 5);
        sg = has_base && (in_base == 5);
        il = (in_mode > 5) || (has_base && in_base == 4) || (has_idx && in_index == 4);
        sb = sg ? in_ss_base : in_ds_base;
        case (in_mode)
            3'd0: a = sb + in_disp;
            3'd1: a = sb + b;
            3'd2: a = sb + b + x;
            3'd3: a = sb + b + in_disp;
            3'd4: a = sb + b + x + in_disp;
            3'd5: a = sb + b + x * (32'd1 << in_scale) + in_disp;
            default: a = '0;
        endcase
        if (il) a = '0;
    endfunction

    // Reference model state update.
    always @(posedge clk) begin
        logic [31:0] a;
        logic sg, il;
        model_live = 1'b1;
        if (!rst_n) begin
            exp_valid = 0; exp_addr = 0; exp_seg = 0; exp_ill = 0; exp_tag = "R1";
        end else begin
            exp_valid = in_valid;
            if (in_valid) begin
                ref_calc(a, sg, il);
                exp_addr = a; exp_seg = sg; exp_ill = il; exp_tag = cur_tag;
            end else begin
                exp_tag = "R2";
            end
        end
    end

    // Comparison on every falling edge.
    always @(negedge clk) begin
        if (model_live) begin
            checks++;
            if (out_valid !== exp_valid || out_addr !== exp_addr ||
                out_seg !== exp_seg || out_illegal !== exp_ill) begin
                errors++;
                $display("FAIL %s: got v=%b a=%h s=%b i=%b expected v=%b a=%h s=%b i=%b",
                         exp_tag, out_valid, out_addr, out_seg, out_illegal,
                         exp_valid, exp_addr, exp_seg, exp_ill);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic load_regs();
        for (int i = 0; i < 8; i++) in_gpr[i*32 +: 32] = regs[i];
    endtask

    task automatic drive(input logic [2:0] m, input logic [2:0] b, input logic [2:0] x,
                         input logic [1:0] s, input logic [31:0] d, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_base = b; in_index = x;
        in_scale = s; in_disp = d; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_mode = 3'(i + 3); in_base = 3'(i); in_index = 3'(i + 1);
            in_disp = in_disp ^ 32'h5A5A_0F0F;
            in_ds_base = in_ds_base + 32'h10;
        end
    endtask

    initial begin
        regs[0] = 32'h0000_1000; regs[1] = 32'h0000_0200; regs[2] = 32'h0003_0000;
        regs[3] = 32'h0010_0000; regs[4] = 32'h7FFF_FFF0; regs[5] = 32'h0000_8000;
        regs[6] = 32'h0000_0040; regs[7] = 32'hFFFF_FFF0;
        load_regs();
        in_ds_base = 32'h2000_0000;
        in_ss_base = 32'h4000_0000;

        // R1: reset held for several edges.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        drive(3'd0, 3'd4, 3'd4, 2'd0, 32'h0000_1234, "R3");     // direct, SP fields ignored
        drive(3'd1, 3'd3, 3'd4, 2'd3, 32'hDEAD_BEEF, "R4");     // indirect, index SP ignored
        drive(3'd1, 3'd6, 3'd0, 2'd0, 32'h0, "R4");
        drive(3'd2, 3'd3, 3'd6, 2'd3, 32'h1111_1111, "R5");
        drive(3'd3, 3'd0, 3'd0, 2'd0, 32'hFFFF_FFF0, "R6");     // negative displacement
        drive(3'd4, 3'd3, 3'd1, 2'd2, 32'h0000_0008, "R7");
        for (int s = 0; s < 4; s++)
            drive(3'd5, 3'd0, 3'd6, 2'(s), 32'h0000_0004, "R8");
        drive(3'd3, 3'd5, 3'd0, 2'd0, 32'h0000_0010, "R9");     // frame pointer base
        drive(3'd4, 3'd5, 3'd2, 2'd0, 32'h0, "R9");
        drive(3'd2, 3'd1, 3'd4, 2'd0, 32'h0, "R10");            // SP index
        drive(3'd3, 3'd4, 3'd0, 2'd0, 32'h8, "R10");            // SP base
        drive(3'd6, 3'd0, 3'd1, 2'd0, 32'h8, "R10");            // undefined mode
        drive(3'd7, 3'd0, 3'd1, 2'd0, 32'h8, "R10");
        drive(3'd5, 3'd5, 3'd4, 2'd2, 32'h8, "R10");            // stack seg and refusal together
        drive(3'd3, 3'd7, 3'd0, 2'd0, 32'h0000_0020, "R11");    // wrap past 2^32
        idle(4);                                                // R2 hold with noisy inputs
        drive(3'd5, 3'd7, 3'd7, 2'd3, 32'h8000_0000, "R11");
        idle(3);

        // Second reset in the middle of activity (R1).
        drive(3'd4, 3'd2, 3'd3, 2'd0, 32'h77, "R7");
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1; cur_tag = "R1";
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;

        // Register values changed between accesses (R5, R8).
        regs[3] = 32'hA000_0000; regs[6] = 32'h1234_5678; load_regs();
        drive(3'd2, 3'd3, 3'd6, 2'd0, 32'h0, "R5");
        drive(3'd5, 3'd3, 3'd6, 2'd3, 32'hFFFF_FFFF, "R8");
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule